// File: doc/BRIEF.md
# Landing-Pad Expectation Tracker

This block holds the one-bit "landing pad expected" flag of a processor hart that enforces forward control-flow integrity. When an indirect branch retires with forward protection on, the flag is set. The next instruction to retire must then be a landing pad, which clears the flag. If any other instruction retires first, the block raises a fault request for one cycle and leaves the flag as it is.

A trap can arrive while the flag is set. The block therefore keeps one saved copy of the flag for each trap target privilege: a supervisor copy and a machine copy. On trap delivery it stores the current flag into the copy for the target privilege and clears the live flag. The matching return instruction reloads the flag from that copy and zeroes the copy. Both saved bits are visible as status outputs, and a status-register write can load them.

The block also produces the three-bit mask of protection status bits that a hypervisor context swap carries. The mask is non-zero only when both environment-level enables are on.

Top module: `lp_expect_tracker`

## Requirements
- R1: During and right after reset, the flag, both saved bits and the fault request are 0. The flag encoding is 1 = landing pad expected, 0 = not expected.
- R2: Forward protection counts as enabled when `fcfi_en` and `ext_present` are both 1. While it is enabled and the flag is 0, a retired indirect branch sets the flag to 1 on the next cycle.
- R3: A retired landing pad (`rt_is_lpad` = 1) clears the flag on the next cycle.
- R4: A retired instruction that is not a landing pad, arriving while the flag is 1 and protection is enabled, drives `lp_fault` high for exactly the next cycle and leaves the flag at 1.
- R5: When a trap is delivered with protection enabled, the pre-trap flag is copied into the saved bit for the target privilege. `trap_to_m` = 0 selects the supervisor bit and 1 selects the machine bit. The other saved bit does not change.
- R6: Trap delivery clears the flag whenever `ext_present` = 1, whether or not `fcfi_en` is set. A retire or status write in the same cycle has no effect and raises no fault.
- R7: A supervisor return with `ret_fcfi_en` and `ext_present` set loads the flag from the supervisor saved bit and zeroes that bit. A machine return does the same with the machine saved bit. If both return strobes are high, the machine return wins, and a trap outranks both.
- R8: A return with `ret_fcfi_en` = 0 leaves the flag and both saved bits unchanged.
- R9: `swap_mask` (bit 0 user forward enable, bit 1 user backward enable, bit 2 supervisor saved bit) is 3'b111 when `menv_cfi` and `henv_cfi` are both 1, and 3'b000 otherwise.
- R10: In a cycle with no trap and no return, `st_we` = 1 loads both saved bits from `st_wd_s` and `st_wd_m`.
- R11: With protection disabled, indirect branches do not set the flag and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_present | input | 1 | Protection extension implemented |
| fcfi_en | input | 1 | Forward protection enabled for the current context |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_is_lpad | input | 1 | The retiring instruction is a landing pad |
| rt_is_ibr | input | 1 | The retiring instruction is an indirect branch |
| trap_take | input | 1 | Trap delivered this cycle |
| trap_to_m | input | 1 | Trap target privilege: 0 supervisor, 1 machine |
| sret_i | input | 1 | Supervisor return executed |
| mret_i | input | 1 | Machine return executed |
| ret_fcfi_en | input | 1 | Forward protection enabled for the return target |
| st_we | input | 1 | Status write of the saved bits |
| st_wd_s | input | 1 | Write data for the supervisor saved bit |
| st_wd_m | input | 1 | Write data for the machine saved bit |
| menv_cfi | input | 1 | Machine environment protection enable |
| henv_cfi | input | 1 | Hypervisor environment protection enable |
| elp_o | output | 1 | Current landing-pad-expected flag |
| spelp_o | output | 1 | Supervisor saved flag |
| mpelp_o | output | 1 | Machine saved flag |
| lp_fault | output | 1 | One-cycle fault request |
| swap_mask | output | 3 | Status bits carried on a context swap |

## Verification
A wrong flag does not always show at once. A stale 1 shows as a spurious `lp_fault` on the next non-landing-pad retire. A stale 0 shows only when a later branch–instruction pair fails to fault. A corrupted saved bit stays hidden until the matching return reloads it, unless the saved-bit status outputs are watched. The bench compares every output against a behavioural model on every clock, so any divergence is reported in the cycle it first reaches a port. Directed sequences cover traps and returns taken while the flag is set.

// File: rtl/lp_expect_tracker.sv
module lp_expect_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_present,
  input  logic       fcfi_en,
  input  logic       rt_valid,
  input  logic       rt_is_lpad,
  input  logic       rt_is_ibr,
  input  logic       trap_take,
  input  logic       trap_to_m,
  input  logic       sret_i,
  input  logic       mret_i,
  input  logic       ret_fcfi_en,
  input  logic       st_we,
  input  logic       st_wd_s,
  input  logic       st_wd_m,
  input  logic       menv_cfi,
  input  logic       henv_cfi,
  output logic       elp_o,
  output logic       spelp_o,
  output logic       mpelp_o,
  output logic       lp_fault,
  output logic [2:0] swap_mask
);

  logic elp_q, sp_q, mp_q, fault_q;
  logic elp_d, sp_d, mp_d, fault_d;

  wire fwd_on  = fcfi_en & ext_present;
  wire ret_on  = ret_fcfi_en & ext_present;
  wire any_ret = sret_i | mret_i;

  always_comb begin
    elp_d   = elp_q;
    sp_d    = sp_q;
    mp_d    = mp_q;
    fault_d = 1'b0;
    if (trap_take) begin
      if (fwd_on) begin
        if (trap_to_m) mp_d = elp_q;
        else           sp_d = elp_q;
      end
      if (ext_present) elp_d = 1'b0;
    end else if (mret_i) begin
      if (ret_on) begin
        elp_d = mp_q;
        mp_d  = 1'b0;
      end
    end else if (sret_i) begin
      if (ret_on) begin
        elp_d = sp_q;
        sp_d  = 1'b0;
      end
    end else begin
      if (st_we) begin
        sp_d = st_wd_s;
        mp_d = st_wd_m;
      end
      if (rt_valid) begin
        if (rt_is_lpad)               elp_d = 1'b0;
        else if (elp_q && fwd_on)     fault_d = 1'b1;
        else if (rt_is_ibr && fwd_on) elp_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elp_q   <= 1'b0;
      sp_q    <= 1'b0;
      mp_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      elp_q   <= elp_d;
      sp_q    <= sp_d;
      mp_q    <= mp_d;
      fault_q <= fault_d;
    end
  end

  assign elp_o     = elp_q;
  assign spelp_o   = sp_q;
  assign mpelp_o   = mp_q;
  assign lp_fault  = fault_q;
  assign swap_mask = (menv_cfi && henv_cfi) ? 3'b111 : 3'b000;

  p_ibr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !any_ret && rt_valid && rt_is_ibr && !rt_is_lpad && fwd_on && !elp_o)
    |=> elp_o);

  p_lpad_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !any_ret && rt_valid && rt_is_lpad) |=> !elp_o);

  p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !any_ret && rt_valid && !rt_is_lpad && elp_o && fwd_on)
    |=> (lp_fault && elp_o));

  p_trap_save_s_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && !trap_to_m && fwd_on) |=> (spelp_o == $past(elp_o) && $stable(mpelp_o)));

  p_trap_save_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_to_m && fwd_on) |=> (mpelp_o == $past(elp_o) && $stable(spelp_o)));

  p_trap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && ext_present) |=> (!elp_o && !lp_fault));

  p_mret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && mret_i && ret_on) |=> (elp_o == $past(mpelp_o) && !mpelp_o));

  p_sret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && sret_i && !mret_i && ret_on) |=> (elp_o == $past(spelp_o) && !spelp_o));

  p_ret_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && any_ret && !ret_fcfi_en) |=> ($stable(elp_o) && $stable(spelp_o) && $stable(mpelp_o)));

  p_no_fault_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_on |=> !lp_fault);

endmodule

// File: tb/lp_expect_tracker_tb_top.sv
module lp_expect_tracker_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_present = 0, fcfi_en = 0, rt_valid = 0, rt_is_lpad = 0, rt_is_ibr = 0;
  logic trap_take = 0, trap_to_m = 0, sret_i = 0, mret_i = 0, ret_fcfi_en = 0;
  logic st_we = 0, st_wd_s = 0, st_wd_m = 0, menv_cfi = 0, henv_cfi = 0;
  logic elp_o, spelp_o, mpelp_o, lp_fault;
  logic [2:0] swap_mask;

  int checks = 0;
  int fails  = 0;
  bit m_elp = 0, m_sp = 0, m_mp = 0, m_fault = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  lp_expect_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .fcfi_en(fcfi_en),
    .rt_valid(rt_valid), .rt_is_lpad(rt_is_lpad), .rt_is_ibr(rt_is_ibr),
    .trap_take(trap_take), .trap_to_m(trap_to_m), .sret_i(sret_i), .mret_i(mret_i),
    .ret_fcfi_en(ret_fcfi_en), .st_we(st_we), .st_wd_s(st_wd_s), .st_wd_m(st_wd_m),
    .menv_cfi(menv_cfi), .henv_cfi(henv_cfi), .elp_o(elp_o), .spelp_o(spelp_o),
    .mpelp_o(mpelp_o), .lp_fault(lp_fault), .swap_mask(swap_mask)
  );

  task automatic cmp(input string req, input logic [2:0] act, input logic [2:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp(tag, {2'b0, elp_o},    {2'b0, m_elp},   "flag");
    cmp(tag, {2'b0, spelp_o},  {2'b0, m_sp},    "supervisor saved bit");
    cmp(tag, {2'b0, mpelp_o},  {2'b0, m_mp},    "machine saved bit");
    cmp(tag, {2'b0, lp_fault}, {2'b0, m_fault}, "fault request");
    cmp("R9", swap_mask, (menv_cfi && henv_cfi) ? 3'b111 : 3'b000, "swap mask");
  endtask

  task automatic model_step();
    bit en, ren, nf;
    en  = fcfi_en && ext_present;
    ren = ret_fcfi_en && ext_present;
    nf  = 0;
    if (!rst_n) begin
      m_elp = 0; m_sp = 0; m_mp = 0; tag = "R1";
    end else if (trap_take) begin
      tag = "R5/R6";
      if (en) begin
        if (trap_to_m) m_mp = m_elp;
        else m_sp = m_elp;
      end
      if (ext_present) m_elp = 0;
    end else if (mret_i || sret_i) begin
      tag = ren ? "R7" : "R8";
      if (ren) begin
        if (mret_i) begin m_elp = m_mp; m_mp = 0; end
        else begin m_elp = m_sp; m_sp = 0; end
      end
    end else begin
      tag = st_we ? "R10" : (en ? "R2/R3/R4" : "R11");
      if (st_we) begin m_sp = st_wd_s; m_mp = st_wd_m; end
      if (rt_valid) begin
        if (rt_is_lpad) m_elp = 0;
        else if (m_elp && en) nf = 1;
        else if (rt_is_ibr && en) m_elp = 1;
      end
    end
    m_fault = nf;
  endtask

  task automatic idle();
    rt_valid = 0; rt_is_lpad = 0; rt_is_ibr = 0; trap_take = 0; trap_to_m = 0;
    sret_i = 0; mret_i = 0; st_we = 0; st_wd_s = 0; st_wd_m = 0;
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic ibr();   idle(); rt_valid = 1; rt_is_ibr = 1; cyc(); endtask
  task automatic lpad();  idle(); rt_valid = 1; rt_is_lpad = 1; cyc(); endtask
  task automatic plain(); idle(); rt_valid = 1; cyc(); endtask
  task automatic trap(input bit to_m); idle(); trap_take = 1; trap_to_m = to_m; cyc(); endtask
  task automatic xret(input bit m, input bit en);
    idle(); ret_fcfi_en = en; if (m) mret_i = 1; else sret_i = 1; cyc(); ret_fcfi_en = 1;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1;
    ext_present = 1; fcfi_en = 1; ret_fcfi_en = 1;
    idle(); cyc();
    // R2, R3
    ibr(); lpad();
    // R4: fault holds the flag
    ibr(); plain(); plain(); lpad();
    // R5, R7 supervisor path
    ibr(); trap(0); xret(0, 1); lpad();
    // R5, R7 machine path; trap with a retire in the same cycle (R6)
    ibr(); idle(); trap_take = 1; trap_to_m = 1; rt_valid = 1; cyc(); xret(1, 1); plain();
    // R8: return with restore disabled
    ibr(); trap(0); xret(0, 0); xret(0, 1); lpad();
    // R6: trap clears even with forward protection off
    ibr(); fcfi_en = 0; trap(0); fcfi_en = 1;
    // R10 status write, R7 both returns
    idle(); st_we = 1; st_wd_s = 1; st_wd_m = 1; cyc();
    idle(); sret_i = 1; mret_i = 1; cyc(); xret(0, 1);
    // R11 disabled
    fcfi_en = 0; ibr(); plain(); fcfi_en = 1;
    // R9
    menv_cfi = 1; idle(); cyc(); henv_cfi = 1; cyc(); menv_cfi = 0; cyc();
    for (int n = 0; n < 4000; n++) begin
      idle();
      rt_valid    = ($urandom % 4) != 0;
      rt_is_lpad  = ($urandom % 3) == 0;
      rt_is_ibr   = ($urandom % 3) == 0;
      trap_take   = ($urandom % 10) == 0;
      trap_to_m   = $urandom % 2;
      sret_i      = ($urandom % 12) == 0;
      mret_i      = ($urandom % 12) == 0;
      ret_fcfi_en = ($urandom % 5) != 0;
      st_we       = ($urandom % 15) == 0;
      st_wd_s     = $urandom % 2;
      st_wd_m     = $urandom % 2;
      fcfi_en     = ($urandom % 6) != 0;
      ext_present = ($urandom % 10) != 0;
      menv_cfi    = $urandom % 2;
      henv_cfi    = $urandom % 2;
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule